// File: doc/BRIEF.md
# Four-Mode Significand Rounding Stage

This block takes a normalised significand that still carries a few extra low-order bits and cuts it down to the target fraction width. It does so under one of four rounding modes chosen per operation by a 2-bit code. It sits after the arithmetic that produced the wide significand, for example an adder, multiplier or divider datapath. It is a single register stage: the operands presented with `in_valid` on one clock edge come out rounded on the next.

The retained field is the hidden bit plus `FRAC_W` fraction bits. The `GRD_W` bits below it are the discarded field. Rounding can add one unit in the last place. If that turns the retained field from all ones into a carry, the result is renormalised to a leading one followed by zeros, and the exponent goes up by one. An exponent that reaches the all-ones code raises an overflow flag. A separate flag reports any loss of precision. NaN handling and the arithmetic upstream lie outside the block.

Top module: `fp_round_unit`

## Requirements
- R1: Results appear exactly one clock after the operands are presented. `out_valid` is high in a cycle exactly when `in_valid` was high on the previous clock edge.
- R2: Mode code 2'b00 (round to nearest) rounds the retained field up by one when the discarded field is above one half of a last-place unit. It leaves the retained field unchanged when the discarded field is below one half.
- R3: In mode 2'b00, a discarded field equal to exactly one half (its top bit 1, all other discarded bits 0) rounds up only when the retained LSB is 1, so the result ends in an even bit.
- R4: Mode code 2'b01 (toward zero) always truncates: the retained field passes through unchanged, whatever the sign.
- R5: Mode code 2'b10 (toward plus infinity) rounds up when the sign is 0 and the discarded field is nonzero. It truncates when the sign is 1.
- R6: Mode code 2'b11 (toward minus infinity) rounds up when the sign is 1 and the discarded field is nonzero. It truncates when the sign is 0.
- R7: `out_inexact` is 1 exactly when the discarded field of that operation was nonzero, in every mode.
- R8: When rounding carries out of the retained field, the output significand is a 1 in the hidden-bit position followed by zeros, and the exponent is the input exponent plus one. Without a carry, the exponent passes through unchanged.
- R9: `out_overflow` is 1 exactly when a rounding carry brings the exponent to the all-ones code (or finds it already there). The output exponent then holds at all ones.
- R10: While reset is asserted, `out_valid`, `out_inexact` and `out_overflow` are 0.
- R11: The output sign equals the input sign; rounding never changes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands on the inputs are to be rounded |
| in_sign | input | 1 | Sign of the value (1 = negative) |
| in_exp | input | EXP_W | Biased exponent |
| in_sig | input | FRAC_W+GRD_W+1 | Normalised significand: hidden bit, fraction, then discarded bits |
| in_mode | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| out_valid | output | 1 | Rounded result valid |
| out_sign | output | 1 | Sign of the result |
| out_exp | output | EXP_W | Exponent after renormalisation |
| out_sig | output | FRAC_W+1 | Rounded significand including hidden bit |
| out_inexact | output | 1 | Some discarded bit was nonzero |
| out_overflow | output | 1 | Rounding carry pushed the exponent to all ones |

## Verification
The bench builds the block with a 4-bit fraction, 3 discarded bits and an 8-bit exponent. This makes the whole normalised significand space of 128 patterns small enough to sweep completely, under every mode and both signs. Every tie, above-tie, below-tie and all-ones carry pattern is therefore hit in each mode. Pairing the sweep with exponents of 1, 77, 253 and 254 reaches both the plain exponent bump and the two paths into overflow. An input exponent already at all ones also exercises saturation.

// File: rtl/fp_round_unit.sv
module fp_round_unit #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int GRD_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sign,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [FRAC_W+GRD_W:0] in_sig,
  input  logic [1:0]        in_mode,
  output logic              out_valid,
  output logic              out_sign,
  output logic [EXP_W-1:0]  out_exp,
  output logic [FRAC_W:0]   out_sig,
  output logic              out_inexact,
  output logic              out_overflow
);
  localparam int SIG_W  = FRAC_W + GRD_W + 1;
  localparam int KEEP_W = FRAC_W + 1;
  localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};
  localparam logic [GRD_W-1:0] HALF = GRD_W'(1) << (GRD_W - 1);
  localparam logic [1:0] RM_NEAR = 2'b00;
  localparam logic [1:0] RM_ZERO = 2'b01;
  localparam logic [1:0] RM_UP   = 2'b10;
  localparam logic [1:0] RM_DOWN = 2'b11;

  logic [KEEP_W-1:0] keep;
  logic [GRD_W-1:0]  disc;
  logic              sticky, above, tie, inc;
  logic [KEEP_W:0]   sum;
  logic              carry;
  logic [KEEP_W-1:0] rnd_sig;
  logic [EXP_W-1:0]  exp_inc, rnd_exp;
  logic              exp_top, ovf;

  assign keep   = in_sig[SIG_W-1:GRD_W];
  assign disc   = in_sig[GRD_W-1:0];
  assign sticky = |disc;
  assign above  = disc > HALF;
  assign tie    = disc == HALF;

  always_comb begin
    unique case (in_mode)
      RM_NEAR: inc = above | (tie & keep[0]);
      RM_ZERO: inc = 1'b0;
      RM_UP:   inc = sticky & ~in_sign;
      RM_DOWN: inc = sticky & in_sign;
      default: inc = 1'b0;
    endcase
  end

  assign sum     = {1'b0, keep} + {{KEEP_W{1'b0}}, inc};
  assign carry   = sum[KEEP_W];
  assign rnd_sig = carry ? sum[KEEP_W:1] : sum[KEEP_W-1:0];

  assign exp_top = in_exp == EXP_MAX;
  assign exp_inc = in_exp + EXP_W'(1);
  assign rnd_exp = !carry ? in_exp : (exp_top ? EXP_MAX : exp_inc);
  assign ovf     = carry & (exp_top | (exp_inc == EXP_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_sign     <= 1'b0;
      out_exp      <= '0;
      out_sig      <= '0;
      out_inexact  <= 1'b0;
      out_overflow <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sign     <= in_sign;
        out_exp      <= rnd_exp;
        out_sig      <= rnd_sig;
        out_inexact  <= sticky;
        out_overflow <= ovf;
      end
    end
  end
endmodule

// File: rtl/fp_round_unit_chk.sv
module fp_round_unit_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int GRD_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_sign,
  input logic [EXP_W-1:0]  in_exp,
  input logic [FRAC_W+GRD_W:0] in_sig,
  input logic [1:0]        in_mode,
  input logic              out_valid,
  input logic              out_sign,
  input logic [EXP_W-1:0]  out_exp,
  input logic [FRAC_W:0]   out_sig,
  input logic              out_inexact,
  input logic              out_overflow
);
  a_r1_valid_on: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_valid_off: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r4_truncate: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'b01) |=>
      (out_sig == $past(in_sig[FRAC_W+GRD_W:GRD_W]) && out_exp == $past(in_exp)));
  a_r5_neg_truncates: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'b10 && in_sign) |=>
      out_sig == $past(in_sig[FRAC_W+GRD_W:GRD_W]));
  a_r6_pos_truncates: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'b11 && !in_sign) |=>
      out_sig == $past(in_sig[FRAC_W+GRD_W:GRD_W]));
  a_r7_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_inexact == ($past(in_sig[GRD_W-1:0]) != '0)));
  a_r7_exact_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sig[GRD_W-1:0] == '0) |=>
      (out_sig == $past(in_sig[FRAC_W+GRD_W:GRD_W]) && !out_overflow));
  a_r9_overflow_exp: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_overflow) |-> out_exp == {EXP_W{1'b1}});
  a_r11_sign: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_sign == $past(in_sign));
  always_comb
    if (!rst_n) a_r10_reset: assert (!out_valid && !out_inexact && !out_overflow);
endmodule

bind fp_round_unit fp_round_unit_chk #(
  .EXP_W(EXP_W), .FRAC_W(FRAC_W), .GRD_W(GRD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
  .in_exp(in_exp), .in_sig(in_sig), .in_mode(in_mode),
  .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp),
  .out_sig(out_sig), .out_inexact(out_inexact), .out_overflow(out_overflow)
);

// File: tb/fp_round_unit_test.sv
module fp_round_unit_test;
  localparam int E = 8;
  localparam int F = 4;
  localparam int G = 3;
  localparam int EMAX = (1 << E) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_sign = 1'b0;
  logic [E-1:0] in_exp = '0;
  logic [F+G:0] in_sig = '0;
  logic [1:0] in_mode = 2'b00;
  logic out_valid, out_sign, out_inexact, out_overflow;
  logic [E-1:0] out_exp;
  logic [F:0] out_sig;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fp_round_unit #(.EXP_W(E), .FRAC_W(F), .GRD_W(G)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
    .in_exp(in_exp), .in_sig(in_sig), .in_mode(in_mode),
    .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp),
    .out_sig(out_sig), .out_inexact(out_inexact), .out_overflow(out_overflow)
  );

  task automatic check(input string req, input int act, input int exp_v);
    compared++;
    if (act != exp_v) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (sig=%0h mode=%0d sign=%0d exp=%0d)",
               req, act, exp_v, in_sig, in_mode, in_sign, in_exp);
    end
  endtask

  task automatic model(input int s, input int e, input int sig, input int m,
                       output int osig, output int oexp, output int oinx, output int oovf);
    int keep, disc, up;
    keep = sig >> G;
    disc = sig % (1 << G);
    up = 0;
    if (m == 0) up = (2*disc > (1 << G)) || (2*disc == (1 << G) && keep % 2 == 1);
    else if (m == 2) up = (s == 0 && disc != 0);
    else if (m == 3) up = (s == 1 && disc != 0);
    osig = keep + up;
    oexp = e;
    oovf = 0;
    if (osig == (1 << (F+1))) begin
      osig = osig / 2;
      oexp = e + 1;
      if (oexp >= EMAX) begin oexp = EMAX; oovf = 1; end
    end
    oinx = (disc != 0);
  endtask

  function automatic string mode_req(input int m);
    case (m)
      0: return "R2/R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic step(input int s, input int e, input int sig, input int m);
    int xs, xe, xi, xo;
    @(negedge clk);
    in_valid = 1'b1; in_sign = s[0]; in_exp = E'(e); in_sig = (F+G+1)'(sig); in_mode = m[1:0];
    model(s, e, sig, m, xs, xe, xi, xo);
    @(posedge clk); #1;
    check("R1", int'(out_valid), 1);
    check(mode_req(m), int'(out_sig), xs);
    check("R8", int'(out_exp), xe);
    check("R7", int'(out_inexact), xi);
    check("R9", int'(out_overflow), xo);
    check("R11", int'(out_sign), s);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
    check("R1", int'(out_valid), 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int exps[5] = '{1, 77, 253, 254, 255};
    repeat (3) @(posedge clk);
    #1;
    check("R10", int'(out_valid), 0);
    check("R10", int'(out_inexact), 0);
    check("R10", int'(out_overflow), 0);
    @(negedge clk); rst_n = 1'b1;
    idle();
    // directed corners, F=4 G=3: sig = hidden|4 frac|3 discarded
    step(0, 10, 8'b1000_0100, 0); // R3 tie, even LSB stays
    step(0, 10, 8'b1000_1100, 0); // R3 tie, odd LSB rounds up
    step(1, 10, 8'b1111_1100, 0); // R8 tie carry-out
    step(0, 254, 8'b1111_1111, 2); // R9 carry into all ones
    step(1, 254, 8'b1111_1111, 2); // R5 negative truncates
    idle();
    for (int ei = 0; ei < 5; ei++)
      for (int s = 0; s < 2; s++)
        for (int m = 0; m < 4; m++)
          for (int sig = (1 << (F+G)); sig < (1 << (F+G+1)); sig++)
            step(s, exps[ei], sig, m);
    idle();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule